// File: doc/BRIEF.md
# Banded Dirty-Region Update Tracker

This block keeps a record of which parts of a framebuffer have been written since the last display refresh. The screen is split into horizontal bands of four scanlines, and each band has its own dirty flag. A writer marks flags through a one-cycle strobe. The strobe selects one of three planes: the indexed-colour plane with one flag per band, or the direct-colour plane or control plane, each with four sub-flags per band. An invalidate pulse marks the whole screen at once.

When a refresh request arrives, the tracker walks the bands from top to bottom. It skips clean bands and joins each run of adjacent dirty bands into one full-width update rectangle. Each rectangle leaves as a first scanline and a line count over a valid/ready handshake, and the walk waits while the consumer holds ready low. When the walk ends, one cycle clears every flag between the lowest and the highest dirty band that the walk found. A mode input decides whether the direct-colour and control sub-flags count towards a band being dirty.

Top module: `dirty_band_tracker`

## Requirements
- R1: A dirty flag covers four scanlines: with only band k dirty, a refresh emits exactly one rectangle with first line 4k and count 4.
- R2: Adjacent dirty bands merge into a single rectangle whose first line is the first line of the lowest band in the run.
- R3: A clean band ends an open run. The count equals the clean band's first line minus the run's first line. Runs separated by clean bands are emitted as separate rectangles, in ascending order.
- R4: A run that is still open at the bottom band is emitted as a final rectangle that reaches line 4·NUM_BANDS.
- R5: After a walk that found dirty bands, all flags from the lowest to the highest dirty band are cleared, so an immediate second refresh with no new marks emits nothing.
- R6: An invalidate pulse sets every flag, so the next refresh emits one rectangle with first line 0 and count 4·NUM_BANDS.
- R7: With deep_mode=1, band k is dirty if its indexed flag is set, or if any sub-flag 4k..4k+3 of the direct plane (mark_plane=1) or the control plane (mark_plane=2) is set. Indexed marks use mark_plane=0 with mark_idx=k.
- R8: With deep_mode=0, marks on the direct and control planes produce no rectangle.
- R9: A mark that arrives in the same cycle as the end-of-walk clear leaves its flag set, and the next refresh reports that band.
- R10: While rect_valid is high and rect_ready is low, the rectangle fields hold steady and the walk does not advance. Each rectangle is delivered exactly once.
- R11: After reset, busy and rect_valid are low. busy is high from the accepted refresh until the clear is done. rect_valid is only high while busy. A refresh request made while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| deep_mode | input | 1 | 1: direct and control sub-flags count towards band dirtiness |
| mark_valid | input | 1 | Set-flag strobe |
| mark_plane | input | 2 | 0 indexed, 1 direct, 2 control |
| mark_idx | input | SUB_W | Band index (plane 0) or sub-flag index (planes 1, 2) |
| invalidate | input | 1 | Set all flags |
| refresh_req | input | 1 | Start a walk when idle |
| busy | output | 1 | Walk, emit or clear in progress |
| rect_valid | output | 1 | Rectangle available |
| rect_ready | input | 1 | Consumer accepts the rectangle |
| rect_first | output | LINE_W | First scanline of the rectangle |
| rect_count | output | LINE_W | Number of scanlines in the rectangle |

## Verification
Two things can fall in the same cycle: a set-flag strobe and the end-of-walk clear of that same flag. The bench holds a mark on one band for the whole of a refresh, so the strobe is still high in the clear cycle. It drops the mark only after busy is seen low. The next refresh must still report that band. The bench also overlaps a second refresh request with a running walk and judges it by busy staying low afterwards.

// File: rtl/dirty_band_pkg.sv
package dirty_band_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_SEND = 2'd2,
        ST_WIPE = 2'd3
    } walk_state_e;

    typedef enum logic [1:0] {
        PL_INDEX  = 2'd0,
        PL_DIRECT = 2'd1,
        PL_CTRL   = 2'd2
    } plane_e;

    localparam int unsigned BAND_SHIFT    = 2;
    localparam int unsigned SUBS_PER_BAND = 4;

endpackage

// File: rtl/dbt_flag_store.sv
module dbt_flag_store
    import dirty_band_pkg::*;
#(
    parameter int unsigned NUM_BANDS = 192,
    parameter int unsigned SUB_W     = 10,
    parameter int unsigned BAND_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 deep_mode,
    input  logic                 mark_valid,
    input  logic [1:0]           mark_plane,
    input  logic [SUB_W-1:0]     mark_idx,
    input  logic                 invalidate,
    input  logic                 clr_en,
    input  logic [BAND_W-1:0]    clr_lo,
    input  logic [BAND_W-1:0]    clr_hi,
    output logic [NUM_BANDS-1:0] band_dirty
);

    for (genvar g = 0; g < NUM_BANDS; g++) begin : g_band
        logic                     idx_flag;
        logic [SUBS_PER_BAND-1:0] dir_flag;
        logic [SUBS_PER_BAND-1:0] ctl_flag;
        logic                     wipe_hit;
        logic                     set_idx;
        logic [SUBS_PER_BAND-1:0] set_dir;
        logic [SUBS_PER_BAND-1:0] set_ctl;

        assign wipe_hit = clr_en && (BAND_W'(g) >= clr_lo) && (BAND_W'(g) <= clr_hi);
        assign set_idx  = mark_valid && (mark_plane == PL_INDEX) && (mark_idx == SUB_W'(g));

        for (genvar k = 0; k < SUBS_PER_BAND; k++) begin : g_sub
            assign set_dir[k] = mark_valid && (mark_plane == PL_DIRECT)
                                && (mark_idx == SUB_W'(g * SUBS_PER_BAND + k));
            assign set_ctl[k] = mark_valid && (mark_plane == PL_CTRL)
                                && (mark_idx == SUB_W'(g * SUBS_PER_BAND + k));
        end

        // A set in the same cycle as a wipe wins.
        always_ff @(posedge clk) begin
            if (rst) begin
                idx_flag <= 1'b0;
                dir_flag <= '0;
                ctl_flag <= '0;
            end else begin
                idx_flag <= (idx_flag & ~wipe_hit) | set_idx | invalidate;
                dir_flag <= (dir_flag & {SUBS_PER_BAND{~wipe_hit}}) | set_dir
                            | {SUBS_PER_BAND{invalidate}};
                ctl_flag <= (ctl_flag & {SUBS_PER_BAND{~wipe_hit}}) | set_ctl
                            | {SUBS_PER_BAND{invalidate}};
            end
        end

        assign band_dirty[g] = idx_flag | (deep_mode & ((|dir_flag) | (|ctl_flag)));
    end

endmodule

// File: rtl/dbt_band_walker.sv
module dbt_band_walker
    import dirty_band_pkg::*;
#(
    parameter int unsigned NUM_BANDS = 192,
    parameter int unsigned BAND_W    = 8,
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned LINE_W    = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 refresh_req,
    input  logic [NUM_BANDS-1:0] band_dirty,
    input  logic                 rect_ready,
    output logic                 busy,
    output logic                 rect_valid,
    output logic [LINE_W-1:0]    rect_first,
    output logic [LINE_W-1:0]    rect_count,
    output logic                 clr_en,
    output logic [BAND_W-1:0]    clr_lo,
    output logic [BAND_W-1:0]    clr_hi
);

    walk_state_e       state;
    logic [CNT_W-1:0]  pos;
    logic [BAND_W-1:0] pos_idx;
    logic              at_end;
    logic              cur_dirty;
    logic              run_open;
    logic [BAND_W-1:0] run_start;
    logic [CNT_W-1:0]  run_len;
    logic              seen;
    logic [BAND_W-1:0] lo_band;
    logic [BAND_W-1:0] hi_band;
    logic [LINE_W-1:0] out_first;
    logic [LINE_W-1:0] out_count;

    assign pos_idx   = pos[BAND_W-1:0];
    assign at_end    = (pos == CNT_W'(NUM_BANDS));
    assign cur_dirty = !at_end && band_dirty[pos_idx];
    assign run_len   = pos - CNT_W'(run_start);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pos       <= '0;
            run_open  <= 1'b0;
            run_start <= '0;
            seen      <= 1'b0;
            lo_band   <= '0;
            hi_band   <= '0;
            out_first <= '0;
            out_count <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (refresh_req) begin
                        state    <= ST_WALK;
                        pos      <= '0;
                        run_open <= 1'b0;
                        seen     <= 1'b0;
                    end
                end
                ST_WALK: begin
                    if (cur_dirty) begin
                        if (!run_open) begin
                            run_open  <= 1'b1;
                            run_start <= pos_idx;
                        end
                        if (!seen) begin
                            seen    <= 1'b1;
                            lo_band <= pos_idx;
                        end
                        hi_band <= pos_idx;
                        pos     <= pos + 1'b1;
                    end else if (run_open) begin
                        out_first <= LINE_W'(run_start) << BAND_SHIFT;
                        out_count <= LINE_W'(run_len) << BAND_SHIFT;
                        run_open  <= 1'b0;
                        state     <= ST_SEND;
                        if (!at_end) begin
                            pos <= pos + 1'b1;
                        end
                    end else if (at_end) begin
                        state <= seen ? ST_WIPE : ST_IDLE;
                    end else begin
                        pos <= pos + 1'b1;
                    end
                end
                ST_SEND: begin
                    if (rect_ready) begin
                        state <= ST_WALK;
                    end
                end
                ST_WIPE: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state != ST_IDLE);
    assign rect_valid = (state == ST_SEND);
    assign rect_first = out_first;
    assign rect_count = out_count;
    assign clr_en     = (state == ST_WIPE);
    assign clr_lo     = lo_band;
    assign clr_hi     = hi_band;

endmodule

// File: rtl/dirty_band_tracker.sv
module dirty_band_tracker
    import dirty_band_pkg::*;
#(
    parameter int unsigned NUM_BANDS = 192,
    localparam int unsigned SUB_W    = $clog2(NUM_BANDS * SUBS_PER_BAND),
    localparam int unsigned LINE_W   = $clog2((NUM_BANDS << BAND_SHIFT) + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              deep_mode,
    input  logic              mark_valid,
    input  logic [1:0]        mark_plane,
    input  logic [SUB_W-1:0]  mark_idx,
    input  logic              invalidate,
    input  logic              refresh_req,
    output logic              busy,
    output logic              rect_valid,
    input  logic              rect_ready,
    output logic [LINE_W-1:0] rect_first,
    output logic [LINE_W-1:0] rect_count
);

    localparam int unsigned BAND_W = $clog2(NUM_BANDS);
    localparam int unsigned CNT_W  = $clog2(NUM_BANDS + 1);

    logic [NUM_BANDS-1:0] band_dirty;
    logic                 clr_en;
    logic [BAND_W-1:0]    clr_lo;
    logic [BAND_W-1:0]    clr_hi;

    dbt_flag_store #(
        .NUM_BANDS (NUM_BANDS),
        .SUB_W     (SUB_W),
        .BAND_W    (BAND_W)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .deep_mode  (deep_mode),
        .mark_valid (mark_valid),
        .mark_plane (mark_plane),
        .mark_idx   (mark_idx),
        .invalidate (invalidate),
        .clr_en     (clr_en),
        .clr_lo     (clr_lo),
        .clr_hi     (clr_hi),
        .band_dirty (band_dirty)
    );

    dbt_band_walker #(
        .NUM_BANDS (NUM_BANDS),
        .BAND_W    (BAND_W),
        .CNT_W     (CNT_W),
        .LINE_W    (LINE_W)
    ) u_walk (
        .clk         (clk),
        .rst         (rst),
        .refresh_req (refresh_req),
        .band_dirty  (band_dirty),
        .rect_ready  (rect_ready),
        .busy        (busy),
        .rect_valid  (rect_valid),
        .rect_first  (rect_first),
        .rect_count  (rect_count),
        .clr_en      (clr_en),
        .clr_lo      (clr_lo),
        .clr_hi      (clr_hi)
    );

endmodule

// File: rtl/dbt_checker.sv
module dbt_checker #(
    parameter int unsigned NUM_BANDS = 192,
    parameter int unsigned LINE_W    = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              rect_valid,
    input logic              rect_ready,
    input logic [LINE_W-1:0] rect_first,
    input logic [LINE_W-1:0] rect_count
);

    localparam int TOTAL_LINES = NUM_BANDS * 4;

    AST_SEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        rect_valid && !rect_ready |=> rect_valid && $stable(rect_first) && $stable(rect_count)) // R10
        else $error("send hold violated");

    AST_LINE_ALIGN: assert property (@(posedge clk) disable iff (rst)
        rect_valid |-> (rect_first[1:0] == 2'b00) && (rect_count[1:0] == 2'b00)) // R1
        else $error("rectangle not band aligned");

    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        rect_valid |-> (rect_count != '0)) // R3
        else $error("empty rectangle");

    AST_IN_SCREEN: assert property (@(posedge clk) disable iff (rst)
        rect_valid |-> (int'(rect_first) + int'(rect_count) <= TOTAL_LINES)) // R4
        else $error("rectangle past bottom");

    AST_SEND_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        rect_valid |-> busy) // R11
        else $error("rectangle while idle");

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        rect_valid && rect_ready |=> busy) // R5
        else $error("walk ended before clear");

endmodule

bind dirty_band_tracker dbt_checker #(
    .NUM_BANDS (NUM_BANDS),
    .LINE_W    (LINE_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .rect_valid (rect_valid),
    .rect_ready (rect_ready),
    .rect_first (rect_first),
    .rect_count (rect_count)
);

// File: tb/tb_dirty_band_tracker.sv
module tb_dirty_band_tracker;

    localparam int NB     = 192;
    localparam int SUB_W  = $clog2(NB * 4);
    localparam int LINE_W = $clog2(NB * 4 + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              deep_mode = 1'b0;
    logic              mark_valid = 1'b0;
    logic [1:0]        mark_plane = 2'd0;
    logic [SUB_W-1:0]  mark_idx = '0;
    logic              invalidate = 1'b0;
    logic              refresh_req = 1'b0;
    logic              busy;
    logic              rect_valid;
    logic              rect_ready = 1'b1;
    logic [LINE_W-1:0] rect_first;
    logic [LINE_W-1:0] rect_count;

    always #5 clk = ~clk;

    dirty_band_tracker #(.NUM_BANDS(NB)) dut (
        .clk         (clk),
        .rst         (rst),
        .deep_mode   (deep_mode),
        .mark_valid  (mark_valid),
        .mark_plane  (mark_plane),
        .mark_idx    (mark_idx),
        .invalidate  (invalidate),
        .refresh_req (refresh_req),
        .busy        (busy),
        .rect_valid  (rect_valid),
        .rect_ready  (rect_ready),
        .rect_first  (rect_first),
        .rect_count  (rect_count)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit shadow [NB];
    int got_first [NB];
    int got_count [NB];
    int n_got;
    int exp_first [NB];
    int exp_count [NB];
    int n_exp;

    task automatic chk(input bit ok, input string tag, input int actual, input int expected);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic mark(input int plane, input int idx);
        @(negedge clk);
        mark_valid = 1'b1;
        mark_plane = 2'(plane);
        mark_idx   = SUB_W'(idx);
        @(negedge clk);
        mark_valid = 1'b0;
    endtask

    task automatic build_expected();
        int start;
        n_exp = 0;
        start = -1;
        for (int b = 0; b <= NB; b++) begin
            if (b < NB && shadow[b]) begin
                if (start < 0) start = b;
            end else if (start >= 0) begin
                exp_first[n_exp] = start * 4;
                exp_count[n_exp] = (b - start) * 4;
                n_exp++;
                start = -1;
            end
        end
    endtask

    // stall: hold ready low three cycles per rectangle; extra_req: refresh again mid-walk
    task automatic run_scan(input string tag, input bit stall, input bit extra_req);
        int wait_ct;
        int pf;
        int pc;
        bit pend;
        build_expected();
        n_got = 0;
        wait_ct = 0;
        pend = 0;
        pf = 0;
        pc = 0;
        @(negedge clk);
        refresh_req = 1'b1;
        @(negedge clk);
        refresh_req = 1'b0;
        for (int it = 0; it < 4000; it++) begin
            if (extra_req) refresh_req = (it == 2);
            if (rect_valid) begin
                if (pend) begin
                    chk(rect_first == LINE_W'(pf), {tag, " R10 first held"}, int'(rect_first), pf);
                    chk(rect_count == LINE_W'(pc), {tag, " R10 count held"}, int'(rect_count), pc);
                end
                pf = int'(rect_first);
                pc = int'(rect_count);
                pend = 1;
                if (!stall || wait_ct == 3) begin
                    rect_ready = 1'b1;
                    if (n_got < NB) begin
                        got_first[n_got] = pf;
                        got_count[n_got] = pc;
                    end
                    n_got++;
                    wait_ct = 0;
                    pend = 0;
                end else begin
                    rect_ready = 1'b0;
                    wait_ct++;
                end
            end else begin
                rect_ready = !stall;
            end
            if (!busy) break;
            @(negedge clk);
        end
        refresh_req = 1'b0;
        rect_ready = 1'b1;
        chk(n_got == n_exp, {tag, " rectangle total"}, n_got, n_exp);
        for (int i = 0; i < n_exp && i < n_got; i++) begin
            chk(got_first[i] == exp_first[i], {tag, " first line"}, got_first[i], exp_first[i]);
            chk(got_count[i] == exp_count[i], {tag, " line count"}, got_count[i], exp_count[i]);
        end
        for (int b = 0; b < NB; b++) shadow[b] = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy == 1'b0, "R11 reset busy", int'(busy), 0);
        chk(rect_valid == 1'b0, "R11 reset valid", int'(rect_valid), 0);
    endtask

    task automatic t_single();
        mark(0, 10); shadow[10] = 1;
        run_scan("R1 single band", 0, 0);
    endtask

    task automatic t_merge();
        mark(0, 3); mark(0, 4); mark(0, 5);
        shadow[3] = 1; shadow[4] = 1; shadow[5] = 1;
        run_scan("R2 merged run", 0, 0);
    endtask

    task automatic t_split_stall();
        mark(0, 0); mark(0, 2); mark(0, 3); mark(0, 7);
        shadow[0] = 1; shadow[2] = 1; shadow[3] = 1; shadow[7] = 1;
        run_scan("R3 R10 split runs stalled", 1, 0);
    endtask

    task automatic t_bottom();
        mark(0, 100); mark(0, 189); mark(0, 190); mark(0, 191);
        shadow[100] = 1; shadow[189] = 1; shadow[190] = 1; shadow[191] = 1;
        run_scan("R4 run at bottom", 0, 0);
        run_scan("R5 rescan after clear", 0, 0);
    endtask

    task automatic t_invalidate();
        @(negedge clk);
        invalidate = 1'b1;
        @(negedge clk);
        invalidate = 1'b0;
        for (int b = 0; b < NB; b++) shadow[b] = 1;
        run_scan("R6 invalidate", 0, 0);
        run_scan("R5 rescan after full", 0, 0);
    endtask

    task automatic t_deep();
        deep_mode = 1'b1;
        mark(1, 20 * 4 + 3); mark(2, 21 * 4); mark(0, 30);
        shadow[20] = 1; shadow[21] = 1; shadow[30] = 1;
        run_scan("R7 deep planes", 0, 0);
    endtask

    task automatic t_shallow();
        deep_mode = 1'b0;
        mark(1, 60 * 4 + 1); mark(2, 61 * 4 + 2);
        run_scan("R8 shallow ignores planes", 0, 0);
        deep_mode = 1'b1;
        shadow[60] = 1; shadow[61] = 1;
        run_scan("R7 stored sub flags", 0, 0);
        deep_mode = 1'b0;
    endtask

    task automatic t_collide();
        @(negedge clk);
        mark_valid = 1'b1;
        mark_plane = 2'd0;
        mark_idx   = SUB_W'(50);
        shadow[50] = 1;
        run_scan("R9 mark during clear first", 0, 0);
        mark_valid = 1'b0;
        shadow[50] = 1;
        run_scan("R9 mark survives clear", 0, 0);
    endtask

    task automatic t_double_req();
        mark(0, 5); shadow[5] = 1;
        run_scan("R11 refresh while busy", 1, 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(busy == 1'b0, "R11 no second walk", int'(busy), 0);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) shadow[b] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        t_merge();
        t_split_stall();
        t_bottom();
        t_invalidate();
        t_deep();
        t_shallow();
        t_collide();
        t_double_req();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule